// File: doc/BRIEF.md
# Dual-Path 16-bit Lane Selection Unit

This unit rearranges a wide vector of 16-bit elements without any arithmetic. A source vector of 64 lanes feeds two independent selection paths, X and Y. Each path is set up by a start lane, two 32-bit words of 4-bit offset entries and a 16-bit reorder word. The path first gathers adjacent lane pairs from the source, with indices that depend on the entry's parity. It then shuffles the lanes inside every group of four. A 32-bit lane mask builds the 32-lane result by taking each lane from X or from Y.

The unit is meant to sit next to a vector register file. Typical uses are reversing, interleaving, de-interleaving and transposing tiles of 16-bit data. The parameter `REG_OUT` selects either a purely combinational datapath or a variant with one cycle of latency. In the registered variant a valid flag accompanies the stored result.

Top module: `lane_select_unit`

## Requirements
- R1: Offset entry e (0..15) fills result lanes 2e and 2e+1 of its path with source lanes p and p+1, where p+1 wraps to lane 0 after lane 63.
- R2: For an even entry e, p = start + 2*off[e].
- R3: For an odd entry e, p = start + 2*off[e] + 2*(off[e-1] + 1).
- R4: Every source index is reduced modulo 64, so sums beyond lane 63 wrap around.
- R5: Entry j of the low offset word sits in bits 4j+3..4j and serves entries 0..7, which are result lanes 0..15. The high offset word holds entries 8..15 in the same layout and serves lanes 16..31. A change in one word leaves the other half of the result unchanged.
- R6: In each four-lane group g, result lane 4g+k takes gathered lane 4g+d. Here d is bits 4k+1..4k of the reorder word, and the upper two bits of each nibble are ignored. For example, 0x3210 keeps the group order and 0x0123 reverses it.
- R7: Result lane i comes from the X path when mask bit i is 0 and from the Y path when it is 1.
- R8: The least significant bit of each start value is ignored, so start 5 behaves exactly like start 4.
- R9: With REG_OUT=1, the result and `out_valid` appear one clock after `in_valid` is sampled high. `out_valid` falls one clock after `in_valid` is sampled low. Synchronous reset clears both `out_valid` and `out_vec` to zero.
- R10: With REG_OUT=0, `out_vec` follows the inputs combinationally and `out_valid` equals `in_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies the source vector and settings |
| in_vec | input | 1024 | Source vector, lane i in bits 16i+15..16i |
| x_start | input | 6 | X path start lane (bit 0 ignored) |
| x_offs_lo | input | 32 | X path offset entries 0..7 |
| x_offs_hi | input | 32 | X path offset entries 8..15 |
| x_square | input | 16 | X path four-lane reorder word |
| y_start | input | 6 | Y path start lane (bit 0 ignored) |
| y_offs_lo | input | 32 | Y path offset entries 0..7 |
| y_offs_hi | input | 32 | Y path offset entries 8..15 |
| y_square | input | 16 | Y path four-lane reorder word |
| sel_mask | input | 32 | Per-lane source choice, 1 picks Y |
| out_valid | output | 1 | Result valid |
| out_vec | output | 512 | Result vector, lane i in bits 16i+15..16i |

## Verification
The bench builds two copies of the unit. The main instance keeps the default REG_OUT=1, which exercises the one-cycle latency, the valid pipeline and the reset clearing of the held result. A second instance with REG_OUT=0 is compared against the same model in the cycle of the stimulus, which reaches the transparent variant. Both copies use the package's 64-in, 32-out geometry. At that size the index wrap, the hi/lo offset word split and a full tile transpose all fit within a handful of directed and pseudo-random vectors.

// File: rtl/lsel_pkg.sv
package lsel_pkg;
    localparam int IN_LANES     = 64;
    localparam int OUT_LANES    = 32;
    localparam int LANE_W       = 16;
    localparam int OFF_W        = 4;
    localparam int SQ_GRP       = 4;
    localparam int WORD_W       = 32;

    localparam int IDX_W        = $clog2(IN_LANES);
    localparam int IN_BITS      = IN_LANES * LANE_W;
    localparam int OUT_BITS     = OUT_LANES * LANE_W;
    localparam int ENTRIES      = OUT_LANES / 2;
    localparam int ENT_PER_WORD = WORD_W / OFF_W;
    localparam int SQ_SEL_W     = $clog2(SQ_GRP);
    localparam int SQ_WORD_W    = SQ_GRP * 4;
    localparam int GROUPS       = OUT_LANES / SQ_GRP;
    localparam int SUM_W        = IDX_W + 3;

    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [SUM_W-1:0]  sum_t;

    typedef struct packed {
        logic [IDX_W-1:0]     start;
        logic [WORD_W-1:0]    offs_lo;
        logic [WORD_W-1:0]    offs_hi;
        logic [SQ_WORD_W-1:0] square;
    } path_cfg_t;

    // Source index of the first lane of a pair; the start LSB is dropped and
    // the result wraps because IN_LANES is a power of two.
    function automatic logic [IDX_W-1:0] pair_index(
        input logic [IDX_W-1:0] start,
        input logic [OFF_W-1:0] cur,
        input logic [OFF_W-1:0] prv,
        input logic             odd
    );
        sum_t sum;
        sum = sum_t'({start[IDX_W-1:1], 1'b0})
            + (sum_t'(cur) << 1)
            + (odd ? ((sum_t'(prv) + sum_t'(1)) << 1) : sum_t'(0));
        return sum[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/lsel_offset_stage.sv
module lsel_offset_stage
    import lsel_pkg::*;
(
    input  lane_t     in_lanes   [IN_LANES],
    input  path_cfg_t cfg,
    output lane_t     pair_lanes [OUT_LANES]
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        localparam int SLOT = e % ENT_PER_WORD;
        logic [WORD_W-1:0] word;
        logic [OFF_W-1:0]  cur;
        logic [OFF_W-1:0]  prv;
        logic [IDX_W-1:0]  p;
        logic [IDX_W-1:0]  p_next;

        assign word = (e < ENT_PER_WORD) ? cfg.offs_lo : cfg.offs_hi;
        assign cur  = word[SLOT*OFF_W +: OFF_W];

        if (e % 2 == 1) begin : g_odd
            assign prv = word[(SLOT-1)*OFF_W +: OFF_W];
            assign p   = pair_index(cfg.start, cur, prv, 1'b1);
        end else begin : g_even
            assign prv = '0;
            assign p   = pair_index(cfg.start, cur, prv, 1'b0);
        end

        assign p_next            = p + IDX_W'(1);
        assign pair_lanes[2*e]   = in_lanes[p];
        assign pair_lanes[2*e+1] = in_lanes[p_next];
    end
endmodule

// File: rtl/lsel_square_stage.sv
module lsel_square_stage
    import lsel_pkg::*;
(
    input  lane_t                data  [OUT_LANES],
    input  logic [SQ_WORD_W-1:0] square,
    output lane_t                lanes [OUT_LANES]
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        lane_t grp [SQ_GRP];
        for (genvar m = 0; m < SQ_GRP; m++) begin : g_src
            assign grp[m] = data[g*SQ_GRP + m];
        end
        for (genvar k = 0; k < SQ_GRP; k++) begin : g_dst
            logic [SQ_SEL_W-1:0] digit;
            assign digit                = square[k*4 +: SQ_SEL_W];
            assign lanes[g*SQ_GRP + k]  = grp[digit];
        end
    end
endmodule

// File: rtl/lsel_lane_mux.sv
module lsel_lane_mux
    import lsel_pkg::*;
(
    input  lane_t                x_lanes [OUT_LANES],
    input  lane_t                y_lanes [OUT_LANES],
    input  logic [OUT_LANES-1:0] mask,
    output logic [OUT_BITS-1:0]  merged
);
    for (genvar i = 0; i < OUT_LANES; i++) begin : g_lane
        assign merged[i*LANE_W +: LANE_W] = mask[i] ? y_lanes[i] : x_lanes[i];
    end
endmodule

// File: rtl/lane_select_unit.sv
module lane_select_unit
    import lsel_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [IN_BITS-1:0]   in_vec,
    input  logic [IDX_W-1:0]     x_start,
    input  logic [WORD_W-1:0]    x_offs_lo,
    input  logic [WORD_W-1:0]    x_offs_hi,
    input  logic [SQ_WORD_W-1:0] x_square,
    input  logic [IDX_W-1:0]     y_start,
    input  logic [WORD_W-1:0]    y_offs_lo,
    input  logic [WORD_W-1:0]    y_offs_hi,
    input  logic [SQ_WORD_W-1:0] y_square,
    input  logic [OUT_LANES-1:0] sel_mask,
    output logic                 out_valid,
    output logic [OUT_BITS-1:0]  out_vec
);
    lane_t               in_lanes [IN_LANES];
    path_cfg_t           cfg      [2];
    logic [OUT_BITS-1:0] comb_vec;

    for (genvar i = 0; i < IN_LANES; i++) begin : g_unpack
        assign in_lanes[i] = in_vec[i*LANE_W +: LANE_W];
    end

    assign cfg[0] = '{start: x_start, offs_lo: x_offs_lo, offs_hi: x_offs_hi, square: x_square};
    assign cfg[1] = '{start: y_start, offs_lo: y_offs_lo, offs_hi: y_offs_hi, square: y_square};

    for (genvar p = 0; p < 2; p++) begin : g_path
        lane_t gathered [OUT_LANES];
        lane_t shuffled [OUT_LANES];

        lsel_offset_stage u_off (
            .in_lanes   (in_lanes),
            .cfg        (cfg[p]),
            .pair_lanes (gathered)
        );

        lsel_square_stage u_sq (
            .data   (gathered),
            .square (cfg[p].square),
            .lanes  (shuffled)
        );
    end

    lsel_lane_mux u_mux (
        .x_lanes (g_path[0].shuffled),
        .y_lanes (g_path[1].shuffled),
        .mask    (sel_mask),
        .merged  (comb_vec)
    );

    if (REG_OUT) begin : g_reg
        logic                valid_q;
        logic [OUT_BITS-1:0] vec_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                valid_q <= 1'b0;
                vec_q   <= '0;
            end else begin
                valid_q <= in_valid;
                if (in_valid) vec_q <= comb_vec;
            end
        end
        assign out_valid = valid_q;
        assign out_vec   = vec_q;
    end else begin : g_comb
        assign out_valid = in_valid;
        assign out_vec   = comb_vec;
    end
endmodule

// File: rtl/lsel_checker.sv
module lsel_checker
    import lsel_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 in_valid,
    input logic [IN_BITS-1:0]   in_vec,
    input logic [IDX_W-1:0]     x_start,
    input logic [WORD_W-1:0]    x_offs_lo,
    input logic [SQ_WORD_W-1:0] x_square,
    input logic [IDX_W-1:0]     y_start,
    input logic [WORD_W-1:0]    y_offs_lo,
    input logic [SQ_WORD_W-1:0] y_square,
    input logic [OUT_LANES-1:0] sel_mask,
    input logic                 out_valid,
    input logic [OUT_BITS-1:0]  out_vec,
    input logic [OUT_BITS-1:0]  comb_vec
);
    lane_t iv [IN_LANES];
    lane_t cv [OUT_LANES];
    for (genvar i = 0; i < IN_LANES; i++) begin : g_iv
        assign iv[i] = in_vec[i*LANE_W +: LANE_W];
    end
    for (genvar i = 0; i < OUT_LANES; i++) begin : g_cv
        assign cv[i] = comb_vec[i*LANE_W +: LANE_W];
    end

    logic [IDX_W-1:0] xs0, xs1, ys0, xodd;
    assign xs0  = {x_start[IDX_W-1:1], 1'b0};
    assign xs1  = xs0 + IDX_W'(1);
    assign ys0  = {y_start[IDX_W-1:1], 1'b0};
    assign xodd = xs0 + IDX_W'({x_offs_lo[7:4], 1'b0})
                      + IDX_W'({x_offs_lo[3:0], 1'b0}) + IDX_W'(2);

    // R1 R2 R8: entry 0 with a zero offset gathers the even start lane and its neighbour
    a_r1_base_pair: assert property (@(posedge clk) disable iff (rst)
        (sel_mask == '0 && x_square == 16'h3210 && x_offs_lo[3:0] == '0)
        |-> (cv[0] == iv[xs0] && cv[1] == iv[xs1]));

    // R3 R4: the first odd entry adds the previous offset plus one pair
    a_r3_odd_entry: assert property (@(posedge clk) disable iff (rst)
        (sel_mask == '0 && x_square == 16'h3210) |-> (cv[2] == iv[xodd]));

    // R6: reverse reorder word flips the first group
    a_r6_square_reverse: assert property (@(posedge clk) disable iff (rst)
        (sel_mask == '0 && x_square == 16'h0123 && x_offs_lo[3:0] == '0)
        |-> (cv[3] == iv[xs0] && cv[2] == iv[xs1]));

    // R7: an all-ones mask delivers the Y path
    a_r7_y_lane: assert property (@(posedge clk) disable iff (rst)
        (sel_mask == '1 && y_square == 16'h3210 && y_offs_lo[3:0] == '0)
        |-> (cv[0] == iv[ys0]));

    if (REG_OUT) begin : g_reg_chk
        // R9: registered result one cycle after an accepted input
        a_r9_latency: assert property (@(posedge clk) disable iff (rst)
            in_valid |=> (out_valid && out_vec == $past(comb_vec)));
        // R9: valid drops after an idle input cycle
        a_r9_idle: assert property (@(posedge clk) disable iff (rst)
            !in_valid |=> !out_valid);
    end
endmodule

bind lane_select_unit lsel_checker #(.REG_OUT(REG_OUT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_vec    (in_vec),
    .x_start   (x_start),
    .x_offs_lo (x_offs_lo),
    .x_square  (x_square),
    .y_start   (y_start),
    .y_offs_lo (y_offs_lo),
    .y_square  (y_square),
    .sel_mask  (sel_mask),
    .out_valid (out_valid),
    .out_vec   (out_vec),
    .comb_vec  (comb_vec)
);

// File: tb/lane_select_unit_tb_top.sv
module lane_select_unit_tb_top;
    import lsel_pkg::*;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 in_valid = 1'b0;
    logic [IN_BITS-1:0]   in_vec = '0;
    logic [IDX_W-1:0]     x_start = '0, y_start = '0;
    logic [WORD_W-1:0]    x_offs_lo = '0, x_offs_hi = '0, y_offs_lo = '0, y_offs_hi = '0;
    logic [SQ_WORD_W-1:0] x_square = 16'h3210, y_square = 16'h3210;
    logic [OUT_LANES-1:0] sel_mask = '0;
    logic                 out_valid, c_valid;
    logic [OUT_BITS-1:0]  out_vec, c_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [OUT_BITS-1:0] exp;
        string               tag;
    } sb_t;
    sb_t sbq[$];

    always #10 clk = ~clk;

    lane_select_unit #(.REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .x_start(x_start), .x_offs_lo(x_offs_lo), .x_offs_hi(x_offs_hi), .x_square(x_square),
        .y_start(y_start), .y_offs_lo(y_offs_lo), .y_offs_hi(y_offs_hi), .y_square(y_square),
        .sel_mask(sel_mask), .out_valid(out_valid), .out_vec(out_vec)
    );

    lane_select_unit #(.REG_OUT(1'b0)) dut_c (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
        .x_start(x_start), .x_offs_lo(x_offs_lo), .x_offs_hi(x_offs_hi), .x_square(x_square),
        .y_start(y_start), .y_offs_lo(y_offs_lo), .y_offs_hi(y_offs_hi), .y_square(y_square),
        .sel_mask(sel_mask), .out_valid(c_valid), .out_vec(c_vec)
    );

    // Reference path written from R1..R6 and R8.
    function automatic logic [OUT_BITS-1:0] ref_path(
        input logic [IN_BITS-1:0] v, input logic [IDX_W-1:0] st,
        input logic [WORD_W-1:0] lo, input logic [WORD_W-1:0] hi,
        input logic [SQ_WORD_W-1:0] sq);
        logic [OUT_BITS-1:0] gath, res;
        for (int e = 0; e < ENTRIES; e++) begin
            logic [WORD_W-1:0] w;
            int o, pv, p;
            w  = (e < 8) ? lo : hi;
            o  = int'(w[(e%8)*4 +: 4]);
            pv = (e % 2 == 1) ? int'(w[((e%8)-1)*4 +: 4]) : 0;
            p  = (int'(st) & ~1) + 2*o + ((e % 2 == 1) ? 2*(pv+1) : 0);
            p  = p % IN_LANES;
            gath[(2*e)*LANE_W +: LANE_W]   = v[p*LANE_W +: LANE_W];
            gath[(2*e+1)*LANE_W +: LANE_W] = v[((p+1)%IN_LANES)*LANE_W +: LANE_W];
        end
        for (int g = 0; g < OUT_LANES/4; g++) begin
            for (int k = 0; k < 4; k++) begin
                int d;
                d = int'(sq[k*4 +: 2]);
                res[(4*g+k)*LANE_W +: LANE_W] = gath[(4*g+d)*LANE_W +: LANE_W];
            end
        end
        return res;
    endfunction

    function automatic logic [OUT_BITS-1:0] ref_all();
        logic [OUT_BITS-1:0] xr, yr, r;
        xr = ref_path(in_vec, x_start, x_offs_lo, x_offs_hi, x_square);
        yr = ref_path(in_vec, y_start, y_offs_lo, y_offs_hi, y_square);
        for (int i = 0; i < OUT_LANES; i++)
            r[i*LANE_W +: LANE_W] = sel_mask[i] ? yr[i*LANE_W +: LANE_W] : xr[i*LANE_W +: LANE_W];
        return r;
    endfunction

    task automatic compare(input string tag, input logic [OUT_BITS-1:0] act,
                           input logic [OUT_BITS-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            for (int i = 0; i < OUT_LANES; i++) begin
                if (act[i*LANE_W +: LANE_W] !== exp[i*LANE_W +: LANE_W]) begin
                    $display("FAIL %s lane %0d actual %h expected %h", tag, i,
                             act[i*LANE_W +: LANE_W], exp[i*LANE_W +: LANE_W]);
                    break;
                end
            end
        end
    endtask

    // Driver: apply at the falling edge, queue the expectation, check the
    // transparent copy right away (R10).
    task automatic drive(input string tag);
        sb_t item;
        in_valid = 1'b1;
        item.exp = ref_all();
        item.tag = tag;
        sbq.push_back(item);
        #2;
        checks++;
        if (c_valid !== 1'b1) begin
            fails++;
            $display("FAIL R10 valid actual %b expected 1", c_valid);
        end
        compare({"R10 ", tag}, c_vec, item.exp);
        @(negedge clk);
    endtask

    function automatic logic [31:0] xs32(input logic [31:0] s);
        logic [31:0] t;
        t = s ^ (s << 13);
        t = t ^ (t >> 17);
        t = t ^ (t << 5);
        return t;
    endfunction

    // Monitor: sample the registered copy halfway between edges.
    always @(posedge clk) begin
        #5;
        if (!rst && out_valid === 1'b1) begin
            if (sbq.size() == 0) begin
                checks++; fails++;
                $display("FAIL R9 unexpected valid actual 1 expected 0");
            end else begin
                sb_t item;
                item = sbq.pop_front();
                compare({"R9 ", item.tag}, out_vec, item.exp);
            end
        end
    end

    initial begin
        logic [31:0] seed;
        logic [OUT_BITS-1:0] keep;
        seed = 32'h1badf00d;
        for (int i = 0; i < IN_LANES; i++) in_vec[i*LANE_W +: LANE_W] = 16'hA000 + 16'(i);
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        checks++;
        if (out_valid !== 1'b0 || out_vec !== '0) begin
            fails++;
            $display("FAIL R9 reset actual %b/%h expected 0/0", out_valid, out_vec[15:0]);
        end

        drive("R1 R2 zero offsets");
        x_start = 6'd4; x_offs_lo = 32'h76543210; x_offs_hi = 32'hfedcba98;
        drive("R3 odd cumulative");
        x_start = 6'd62; x_offs_lo = 32'hffffffff; x_offs_hi = 32'hffffffff;
        drive("R4 wrap");
        x_start = 6'd0; x_offs_lo = 32'h01234567; x_offs_hi = 32'h0;
        drive("R5 low word");
        x_offs_hi = 32'h01234567;
        drive("R5 high word");
        x_square = 16'h0123;
        drive("R6 reverse");
        x_square = 16'hF1E2;
        drive("R6 upper bits ignored");
        x_square = 16'h3210; x_start = 6'd4; x_offs_lo = 32'h00003120;
        keep = ref_all();
        drive("R8 even start");
        x_start = 6'd5;
        // R8: odd start must match the even one
        checks++;
        if (ref_all() !== keep) begin
            fails++;
            $display("FAIL R8 model mismatch actual %h expected %h", ref_all(), keep);
        end
        drive("R8 odd start");
        for (int i = 0; i < IN_LANES; i++) in_vec[i*LANE_W +: LANE_W] = 16'((i*37) ^ 16'h5a5a);
        x_start = 6'd8; y_start = 6'd20; y_offs_lo = 32'h10203040; y_square = 16'h1032;
        sel_mask = 32'hAAAA5555;
        drive("R7 mixed mask");
        // R7: 2x2-tile transpose setup
        for (int i = 0; i < IN_LANES; i++) in_vec[i*LANE_W +: LANE_W] = 16'(i);
        x_start = 6'd0;  x_offs_lo = 32'h00000800; x_offs_hi = 32'h00000a02; x_square = 16'h3120;
        y_start = 6'd32; y_offs_lo = 32'h08000000; y_offs_hi = 32'h0a020000; y_square = 16'h3120;
        sel_mask = 32'hFF00FF00;
        drive("R7 tile transpose");
        for (int n = 0; n < 12; n++) begin
            for (int i = 0; i < IN_LANES; i += 2) begin
                seed = xs32(seed);
                in_vec[i*LANE_W +: 2*LANE_W] = seed;
            end
            seed = xs32(seed); x_offs_lo = seed;
            seed = xs32(seed); x_offs_hi = seed;
            seed = xs32(seed); y_offs_lo = seed;
            seed = xs32(seed); y_offs_hi = seed;
            seed = xs32(seed); sel_mask  = seed;
            seed = xs32(seed); x_start = seed[5:0]; y_start = seed[11:6];
            x_square = seed[31:16]; y_square = seed[27:12];
            drive("R1 R3 R7 random");
        end
        in_valid = 1'b0;
        #2;
        checks++;
        if (c_valid !== 1'b0) begin
            fails++;
            $display("FAIL R10 idle valid actual %b expected 0", c_valid);
        end
        repeat (2) @(negedge clk);
        // R9: valid drops after idle input, all results consumed
        checks++;
        if (out_valid !== 1'b0 || sbq.size() != 0) begin
            fails++;
            $display("FAIL R9 idle actual %b/%0d expected 0/0", out_valid, sbq.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule